// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block maps a 16-bit virtual address onto an 18-bit or 22-bit physical address through a set of page descriptors. The virtual space is cut into eight pages. Each processor mode (kernel, supervisor, user) owns one bank of eight instruction-space descriptors and one bank of eight data-space descriptors. Each descriptor pairs a base word with a control word. The control word carries a permission code, a page length and a growth direction. The descriptor storage sits outside the block and arrives as two flat input vectors. The control registers that switch translation on, widen the address and enable data space also arrive as inputs.

A request presents the virtual address, the mode, an instruction/data selector, a write flag and a byte flag. One cycle later the block returns the physical address and a single abort strobe with a cause code. It also returns the write requests the owner of the registers must apply. These are a capture word for the error/status register, which is offered only while that register is not frozen, and set requests for the accessed and written flags of the descriptor involved.

Top module: `mmu_xlate`

## Requirements
- R1: When translation is off, `paddr_o` equals the virtual address zero-extended, and no abort, status capture or descriptor mark is produced.
- R2: Translation is on when `sr0_i[0]` is 1, or when the request is a write and `sr0_i[8]` is 1.
- R3: When translating, the page is `vaddr_i[15:13]` and the physical address is the descriptor base word times 64 plus `vaddr_i[12:0]`.
- R4: The translated address is cut to its low 18 bits unless `sr3_i[4]` is 1, in which case all 22 bits are kept.
- R5: Data-space descriptors are used only for a data request whose mode has its enable set: kernel (mode 2'b00) uses `sr3_i[2]`, supervisor (2'b01) uses `sr3_i[1]`, user (2'b11) uses `sr3_i[0]`. Every other access uses instruction-space descriptors. The descriptor index is mode*16 + dspace*8 + page.
- R6: The permission code is control bits 2:0. A write aborts unless the code is 6. A read aborts when the code is 0, 1, 3, 4 or 7. The cause code for this abort is 2.
- R7: The length is control bits 14:8 and is compared with `vaddr_i[12:6]`. When control bit 3 is 0, a block above the length aborts. When it is 1, a block below the length aborts. The cause code is 3.
- R8: A translated address at or above `MEM_BYTES` and below the I/O window aborts as non-resident with cause code 1. The I/O window is the top 8 KiB of the active width.
- R9: Only one cause is reported per access. Non-resident wins over permission, and permission wins over length.
- R10: An abort asserts `sr0_we_o` only if `sr0_i[15:13]` are all 0. The offered word has bit 15, 14 or 13 set for non-resident, length or permission, bits 6:5 set to the mode, bit 4 set to the data-space flag and bits 3:1 set to the page. Bit 12 is 0, and all other bits are copied from `sr0_i`.
- R11: A translated write that aborts raises `desc_abort_mark_o` (control bit 7). A translated word write to an even address that does not abort raises `desc_write_mark_o` (control bit 6). `desc_idx_o` names the descriptor in both cases.
- R12: Every response appears on the cycle after its request. After reset, `rsp_valid_o`, `abort_o`, `sr0_we_o` and the marks are 0. `abort_o` is high only on a response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Request strobe |
| vaddr_i | input | 16 | Virtual address |
| mode_i | input | 2 | Processor mode: 00 kernel, 01 supervisor, 11 user |
| dspace_i | input | 1 | Data-space access |
| wr_i | input | 1 | Write access |
| byte_i | input | 1 | Byte access |
| sr0_i | input | 16 | Error/status control register |
| sr3_i | input | 16 | Extension control register |
| pdr_flat_i | input | 1024 | 64 control words, word k at bits 16k+15:16k |
| par_flat_i | input | 1024 | 64 base words, same layout |
| rsp_valid_o | output | 1 | Response valid |
| paddr_o | output | 22 | Physical address |
| abort_o | output | 1 | Abort strobe |
| cause_o | output | 2 | 0 none, 1 non-resident, 2 permission, 3 length |
| sr0_we_o | output | 1 | Status capture write enable |
| sr0_next_o | output | 16 | Status capture value |
| desc_abort_mark_o | output | 1 | Set control bit 7 of the descriptor |
| desc_write_mark_o | output | 1 | Set control bit 6 of the descriptor |
| desc_idx_o | output | 6 | Descriptor index for the marks |

## Verification
On every cycle, the assertions check the one-cycle response timing, the identity mapping while translation is off, and the upper bits staying clear in 18-bit mode. They also check that status capture happens only from an unfrozen register with exactly one cause bit, and that each descriptor mark goes with the right kind of access and outcome. The exact physical sums, the choice between data and instruction banks, the permission and length decisions at their boundaries, and the cause priority depend on descriptor contents. Only the bench's scenarios can show those, by comparing each response against an independently computed expectation.

// File: rtl/mmu_xlate_pkg.sv
`timescale 1ns/1ps
package mmu_xlate_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_NONRES = 2'd1,
      CAUSE_ACCESS = 2'd2,
      CAUSE_LENGTH = 2'd3
   } abort_cause_e;

   localparam logic [1:0] MODE_KERNEL = 2'b00;
   localparam logic [1:0] MODE_SUPER  = 2'b01;
   localparam logic [1:0] MODE_USER   = 2'b11;

   // per-mode data-space enable taken from the extension register low bits
   function automatic logic dspace_on(input logic [1:0] mode, input logic [2:0] ena);
      case (mode)
         MODE_KERNEL: dspace_on = ena[2];
         MODE_SUPER:  dspace_on = ena[1];
         MODE_USER:   dspace_on = ena[0];
         default:     dspace_on = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/mmu_desc_pick.sv
`timescale 1ns/1ps
module mmu_desc_pick #(
   parameter int ENTRIES = 64,
   parameter int WORD_W  = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES*WORD_W-1:0] flat_i,
   input  logic [IDX_W-1:0]          idx_i,
   output logic [WORD_W-1:0]         word_o
);
   logic [WORD_W-1:0] words [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
      assign words[g] = flat_i[g*WORD_W +: WORD_W];
   end

   assign word_o = words[idx_i];
endmodule

// File: rtl/mmu_access_check.sv
`timescale 1ns/1ps
module mmu_access_check
   import mmu_xlate_pkg::*;
#(
   parameter int PA_W      = 22,
   parameter int LEN_W     = 7,
   parameter int DESC_W    = 16,
   parameter int MEM_BYTES = 196608
) (
   input  logic [DESC_W-1:0] pdr_i,
   input  logic [LEN_W-1:0]  blk_i,
   input  logic              wr_i,
   input  logic [PA_W-1:0]   pa_i,
   input  logic [PA_W-1:0]   io_base_i,
   output abort_cause_e      cause_o
);
   localparam logic [PA_W-1:0] MEM_TOP = PA_W'(MEM_BYTES);

   logic [2:0]       perm;
   logic [LEN_W-1:0] limit;
   logic             grows_down;
   logic             perm_bad, len_bad, absent;
   logic             unused_ctl;

   assign perm       = pdr_i[2:0];
   assign limit      = pdr_i[8 +: LEN_W];
   assign grows_down = pdr_i[3];
   assign unused_ctl = ^{pdr_i[DESC_W-1:8+LEN_W], pdr_i[7:4]};

   always_comb begin
      if (wr_i) perm_bad = (perm != 3'd6);
      else      perm_bad = (perm == 3'd0) || (perm == 3'd1) || (perm == 3'd3) ||
                           (perm == 3'd4) || (perm == 3'd7);
      len_bad = grows_down ? (blk_i < limit) : (blk_i > limit);
      absent  = (pa_i >= MEM_TOP) && (pa_i < io_base_i);
      // fixed priority: residency, then permission, then length
      if (absent)        cause_o = CAUSE_NONRES;
      else if (perm_bad) cause_o = CAUSE_ACCESS;
      else if (len_bad)  cause_o = CAUSE_LENGTH;
      else               cause_o = CAUSE_NONE;
   end
endmodule

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate
   import mmu_xlate_pkg::*;
#(
   parameter int VA_W      = 16,
   parameter int PAGE_W    = 3,
   parameter int BLK_W     = 6,
   parameter int PA_W      = 22,
   parameter int NARROW_W  = 18,
   parameter int DESC_W    = 16,
   parameter int IO_BYTES  = 8192,
   parameter int MEM_BYTES = 196608,
   parameter bit WIDE_EN   = 1'b1,
   localparam int OFF_W    = VA_W - PAGE_W,
   localparam int LEN_W    = OFF_W - BLK_W,
   localparam int IDX_W    = 2 + 1 + PAGE_W,
   localparam int ENTRIES  = 1 << IDX_W,
   localparam int FLAT_W   = ENTRIES * DESC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [VA_W-1:0]   vaddr_i,
   input  logic [1:0]        mode_i,
   input  logic              dspace_i,
   input  logic              wr_i,
   input  logic              byte_i,
   input  logic [15:0]       sr0_i,
   input  logic [15:0]       sr3_i,
   input  logic [FLAT_W-1:0] pdr_flat_i,
   input  logic [FLAT_W-1:0] par_flat_i,
   output logic              rsp_valid_o,
   output logic [PA_W-1:0]   paddr_o,
   output logic              abort_o,
   output logic [1:0]        cause_o,
   output logic              sr0_we_o,
   output logic [15:0]       sr0_next_o,
   output logic              desc_abort_mark_o,
   output logic              desc_write_mark_o,
   output logic [IDX_W-1:0]  desc_idx_o
);
   localparam int SUM_W = PA_W + 1;
   localparam logic [PA_W-1:0] IO_WIDE   = PA_W'((64'd1 << PA_W) - 64'(IO_BYTES));
   localparam logic [PA_W-1:0] IO_NARROW = PA_W'((64'd1 << NARROW_W) - 64'(IO_BYTES));

   // elaboration-time parameter checks
   if (PAGE_W != 3) begin : g_bad_page
      $error("PAGE_W must be 3: the status word holds a 3-bit page field");
   end
   if (LEN_W > 7 || LEN_W < 1) begin : g_bad_len
      $error("OFF_W - BLK_W must fit the 7-bit length field");
   end
   if (PA_W < NARROW_W || DESC_W + BLK_W > SUM_W) begin : g_bad_pa
      $error("physical width must cover the narrow width and base*block");
   end
   if (DESC_W != 16) begin : g_bad_desc
      $error("descriptor words are 16 bits");
   end

   logic              xlate_on, use_d, wide_sel, frozen;
   logic [PAGE_W-1:0] page;
   logic [OFF_W-1:0]  offset;
   logic [LEN_W-1:0]  blk;
   logic [IDX_W-1:0]  idx;
   logic [DESC_W-1:0] pdr, par;
   logic [SUM_W-1:0]  full_sum;
   logic [PA_W-1:0]   pa_mapped, pa_nxt, io_base;
   abort_cause_e      chk_cause, cause_nxt;
   logic [15:0]       capture;
   logic              unused_bits;

   assign xlate_on = sr0_i[0] | (wr_i & sr0_i[8]);
   assign page     = vaddr_i[VA_W-1 -: PAGE_W];
   assign offset   = vaddr_i[OFF_W-1:0];
   assign blk      = vaddr_i[OFF_W-1:BLK_W];
   assign use_d    = dspace_i & dspace_on(mode_i, sr3_i[2:0]);
   assign idx      = {mode_i, use_d, page};

   mmu_desc_pick #(.ENTRIES(ENTRIES), .WORD_W(DESC_W)) u_pick_pdr (
      .flat_i(pdr_flat_i), .idx_i(idx), .word_o(pdr));
   mmu_desc_pick #(.ENTRIES(ENTRIES), .WORD_W(DESC_W)) u_pick_par (
      .flat_i(par_flat_i), .idx_i(idx), .word_o(par));

   // variant: extended width honoured or tied to the narrow width
   if (WIDE_EN) begin : g_wide
      assign wide_sel = sr3_i[4];
      assign unused_bits = ^{sr3_i[15:5], sr3_i[3], full_sum[PA_W]};
   end else begin : g_narrow
      assign wide_sel = 1'b0;
      assign unused_bits = ^{sr3_i[15:3], full_sum[PA_W]};
   end

   assign full_sum  = SUM_W'({par, {BLK_W{1'b0}}}) + SUM_W'(offset);
   assign pa_mapped = wide_sel ? full_sum[PA_W-1:0] : PA_W'(full_sum[NARROW_W-1:0]);
   assign io_base   = wide_sel ? IO_WIDE : IO_NARROW;

   mmu_access_check #(.PA_W(PA_W), .LEN_W(LEN_W), .DESC_W(DESC_W), .MEM_BYTES(MEM_BYTES)) u_check (
      .pdr_i(pdr), .blk_i(blk), .wr_i(wr_i), .pa_i(pa_mapped),
      .io_base_i(io_base), .cause_o(chk_cause));

   assign cause_nxt = xlate_on ? chk_cause : CAUSE_NONE;
   assign pa_nxt    = xlate_on ? pa_mapped : PA_W'(vaddr_i);
   assign frozen    = |sr0_i[15:13];

   always_comb begin
      capture       = sr0_i & 16'h0F81;
      capture[15]   = (cause_nxt == CAUSE_NONRES);
      capture[14]   = (cause_nxt == CAUSE_LENGTH);
      capture[13]   = (cause_nxt == CAUSE_ACCESS);
      capture[6:5]  = mode_i;
      capture[4]    = use_d;
      capture[3:1]  = page;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o       <= 1'b0;
         paddr_o           <= '0;
         abort_o           <= 1'b0;
         cause_o           <= CAUSE_NONE;
         sr0_we_o          <= 1'b0;
         sr0_next_o        <= '0;
         desc_abort_mark_o <= 1'b0;
         desc_write_mark_o <= 1'b0;
         desc_idx_o        <= '0;
      end else begin
         rsp_valid_o <= req_i;
         if (req_i) begin
            paddr_o           <= pa_nxt;
            abort_o           <= (cause_nxt != CAUSE_NONE);
            cause_o           <= cause_nxt;
            sr0_we_o          <= (cause_nxt != CAUSE_NONE) && !frozen;
            sr0_next_o        <= capture;
            desc_abort_mark_o <= xlate_on && wr_i && (cause_nxt != CAUSE_NONE);
            desc_write_mark_o <= xlate_on && wr_i && !byte_i && !vaddr_i[0] &&
                                 (cause_nxt == CAUSE_NONE);
            desc_idx_o        <= idx;
         end else begin
            abort_o           <= 1'b0;
            cause_o           <= CAUSE_NONE;
            sr0_we_o          <= 1'b0;
            desc_abort_mark_o <= 1'b0;
            desc_write_mark_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mmu_xlate_chk.sv
`timescale 1ns/1ps
module mmu_xlate_chk #(
   parameter int VA_W     = 16,
   parameter int PA_W     = 22,
   parameter int NARROW_W = 18
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_i,
   input logic [VA_W-1:0] vaddr_i,
   input logic            wr_i,
   input logic            byte_i,
   input logic            en_bit_i,
   input logic            wen_bit_i,
   input logic [2:0]      frz_i,
   input logic            wide_bit_i,
   input logic            rsp_valid_o,
   input logic [PA_W-1:0] paddr_o,
   input logic            abort_o,
   input logic [1:0]      cause_o,
   input logic            sr0_we_o,
   input logic [2:0]      cap_cause_o,
   input logic            desc_abort_mark_o,
   input logic            desc_write_mark_o
);
   assert_bypass_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_i && !en_bit_i && !(wr_i && wen_bit_i)) |->
         (paddr_o == PA_W'($past(vaddr_i))) && !abort_o && !sr0_we_o && !desc_abort_mark_o);

   assert_narrow_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_i && !wide_bit_i) |-> (paddr_o[PA_W-1:NARROW_W] == '0));

   assert_single_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> (abort_o == (cause_o != 2'd0)));

   assert_frozen_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sr0_we_o |-> abort_o && ($past(frz_i) == 3'b000));

   assert_capture_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sr0_we_o |-> ($countones(cap_cause_o) == 1));

   assert_abort_mark_R11: assert property (@(posedge clk) disable iff (!rst_n)
      desc_abort_mark_o |-> abort_o && $past(wr_i));

   assert_write_mark_R11: assert property (@(posedge clk) disable iff (!rst_n)
      desc_write_mark_o |-> !abort_o && $past(wr_i && !byte_i && !vaddr_i[0]));

   assert_marks_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({desc_abort_mark_o, desc_write_mark_o}));

   assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o == $past(req_i));

   assert_strobe_in_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> rsp_valid_o);
endmodule

bind mmu_xlate mmu_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .NARROW_W(NARROW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .vaddr_i(vaddr_i), .wr_i(wr_i),
   .byte_i(byte_i), .en_bit_i(sr0_i[0]), .wen_bit_i(sr0_i[8]), .frz_i(sr0_i[15:13]),
   .wide_bit_i(sr3_i[4]), .rsp_valid_o(rsp_valid_o), .paddr_o(paddr_o),
   .abort_o(abort_o), .cause_o(cause_o), .sr0_we_o(sr0_we_o),
   .cap_cause_o(sr0_next_o[15:13]), .desc_abort_mark_o(desc_abort_mark_o),
   .desc_write_mark_o(desc_write_mark_o));

// File: tb/mmu_xlate_bench.sv
`timescale 1ns/1ps
module mmu_xlate_bench;
   localparam int MEMB = 196608;

   typedef struct packed {
      logic [21:0] pa;
      logic [1:0]  cause;
      logic        we;
      logic [15:0] sr0n;
      logic        am;
      logic        wm;
      logic [5:0]  idx;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, dsp = 1'b0, wr = 1'b0, byt = 1'b0;
   logic [15:0] va = '0, sr0_r = '0, sr3_r = '0;
   logic [1:0] md = '0;
   logic [15:0] pdr_m [64];
   logic [15:0] par_m [64];
   logic [1023:0] pdr_flat, par_flat;

   logic rsp_valid, abort, sr0_we, am, wm;
   logic [21:0] paddr;
   logic [1:0] cause;
   logic [15:0] sr0n;
   logic [5:0] didx;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   exp_t exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 64; i++) begin
         pdr_flat[i*16 +: 16] = pdr_m[i];
         par_flat[i*16 +: 16] = par_m[i];
      end
   end

   mmu_xlate u_mmu_xlate (
      .clk(clk), .rst_n(rst_n), .req_i(req), .vaddr_i(va), .mode_i(md),
      .dspace_i(dsp), .wr_i(wr), .byte_i(byt), .sr0_i(sr0_r), .sr3_i(sr3_r),
      .pdr_flat_i(pdr_flat), .par_flat_i(par_flat), .rsp_valid_o(rsp_valid),
      .paddr_o(paddr), .abort_o(abort), .cause_o(cause), .sr0_we_o(sr0_we),
      .sr0_next_o(sr0n), .desc_abort_mark_o(am), .desc_write_mark_o(wm),
      .desc_idx_o(didx));

   function automatic logic [15:0] ctl(int len, bit down, int perm);
      return 16'((len << 8) | (int'(down) << 3) | perm);
   endfunction

   function automatic int slot(int m, int d, int pg);
      return m * 16 + d * 8 + pg;
   endfunction

   // expectation built from the requirements
   function automatic exp_t predict(logic [15:0] a, logic [1:0] m, logic ds, logic w, logic b);
      exp_t e;
      int pg, d, i, perm, blk, len, c;
      longint full, pa, io;
      bit nonres, pbad, lbad;
      e = '0;
      if (!(sr0_r[0] || (w && sr0_r[8]))) begin
         e.pa = 22'(a);
         return e;
      end
      pg = int'(a[15:13]);
      d  = int'(ds && ((m == 2'b00 && sr3_r[2]) || (m == 2'b01 && sr3_r[1]) ||
                       (m == 2'b11 && sr3_r[0])));
      i  = slot(int'(m), d, pg);
      full = longint'(par_m[i]) * 64 + longint'(a[12:0]);
      pa = sr3_r[4] ? full % 4194304 : full % 262144;
      io = sr3_r[4] ? 4194304 - 8192 : 262144 - 8192;
      nonres = (pa >= MEMB) && (pa < io);
      perm = int'(pdr_m[i][2:0]);
      pbad = w ? (perm != 6) : (perm == 0 || perm == 1 || perm == 3 || perm == 4 || perm == 7);
      blk = int'(a[12:6]);
      len = int'(pdr_m[i][14:8]);
      lbad = pdr_m[i][3] ? (blk < len) : (blk > len);
      c = nonres ? 1 : pbad ? 2 : lbad ? 3 : 0;
      e.pa = 22'(pa);
      e.cause = 2'(c);
      e.we = (c != 0) && (sr0_r[15:13] == 3'b000);
      e.sr0n = sr0_r & 16'h0F81;
      if (c == 1) e.sr0n[15] = 1'b1;
      if (c == 3) e.sr0n[14] = 1'b1;
      if (c == 2) e.sr0n[13] = 1'b1;
      e.sr0n[6:5] = m;
      e.sr0n[4] = d[0];
      e.sr0n[3:1] = a[15:13];
      e.am = (c != 0) && w;
      e.wm = (c == 0) && w && !b && !a[0];
      e.idx = 6'(i);
      return e;
   endfunction

   task automatic issue(string tag, logic [15:0] a, logic [1:0] m, logic ds,
                        logic w, logic b, bit keep = 1'b0);
      @(negedge clk);
      va = a; md = m; dsp = ds; wr = w; byt = b; req = 1'b1;
      exp_q.push_back(predict(a, m, ds, w, b));
      tag_q.push_back(tag);
      if (!keep) begin
         @(negedge clk);
         req = 1'b0;
      end
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         req = 1'b0;
      end
   endtask

   task automatic check(string tag, bit ok, string act, string expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %s expected %s", tag, act, expv);
      end
   endtask

   // monitor: pops expectations as responses arrive
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check("R12", 1'b0, "response", "no pending request");
         end else begin
            exp_t e;
            string t;
            bit ok;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            ok = (paddr == e.pa) && (cause == e.cause) && (abort == (e.cause != 0)) &&
                 (sr0_we == e.we) && (!e.we || sr0n == e.sr0n) &&
                 (am == e.am) && (wm == e.wm) && (!(e.am || e.wm) || didx == e.idx);
            check(t, ok,
               $sformatf("pa=%h cause=%0d abort=%b we=%b sr0n=%h am=%b wm=%b idx=%0d",
                         paddr, cause, abort, sr0_we, sr0n, am, wm, didx),
               $sformatf("pa=%h cause=%0d abort=%b we=%b sr0n=%h am=%b wm=%b idx=%0d",
                         e.pa, e.cause, e.cause != 0, e.we, e.sr0n, e.am, e.wm, e.idx));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         pdr_m[i] = ctl(127, 1'b0, 6);
         par_m[i] = 16'h0000;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 reset", !rsp_valid && !abort && !sr0_we && !am && !wm,
            $sformatf("v=%b a=%b we=%b", rsp_valid, abort, sr0_we), "all zero");

      // R1: translation off
      issue("R1 read bypass", 16'hA5A4, 2'b11, 1'b1, 1'b0, 1'b0);
      issue("R1 write bypass", 16'h1234, 2'b00, 1'b0, 1'b1, 1'b0);

      // R2: write-only enable
      par_m[slot(0, 0, 1)] = 16'h0400;
      sr0_r = 16'h0100;
      issue("R2 write translated", 16'h2222, 2'b00, 1'b0, 1'b1, 1'b0);
      issue("R2 read passes", 16'h2222, 2'b00, 1'b0, 1'b0, 1'b0);

      // R3: base plus offset
      sr0_r = 16'h0001;
      par_m[slot(0, 0, 2)] = 16'h0345;
      par_m[slot(1, 0, 7)] = 16'h0010;
      issue("R3 kernel page2", 16'h4123, 2'b00, 1'b0, 1'b0, 1'b0);
      issue("R3 super page7", 16'hE001, 2'b01, 1'b0, 1'b0, 1'b0);

      // R4: width selection
      par_m[slot(0, 0, 3)] = 16'hFFC0;
      issue("R4 narrow cut", 16'h6010, 2'b00, 1'b0, 1'b0, 1'b0);
      sr3_r = 16'h0010;
      issue("R4 wide kept", 16'h6010, 2'b00, 1'b0, 1'b0, 1'b0);
      par_m[slot(0, 0, 3)] = 16'h1000;
      sr3_r = 16'h0000;
      issue("R4 narrow wrap", 16'h6010, 2'b00, 1'b0, 1'b0, 1'b0);

      // R5: data space selection
      par_m[slot(3, 0, 0)] = 16'h0011;
      par_m[slot(3, 1, 0)] = 16'h0022;
      par_m[slot(0, 1, 0)] = 16'h0033;
      par_m[slot(0, 0, 0)] = 16'h0044;
      sr3_r = 16'h0001;
      issue("R5 user D", 16'h0100, 2'b11, 1'b1, 1'b0, 1'b0);
      issue("R5 user I", 16'h0100, 2'b11, 1'b0, 1'b0, 1'b0);
      issue("R5 kernel no enable", 16'h0100, 2'b00, 1'b1, 1'b0, 1'b0);
      sr3_r = 16'h0004;
      issue("R5 user no enable", 16'h0100, 2'b11, 1'b1, 1'b0, 1'b0);
      issue("R5 kernel D", 16'h0100, 2'b00, 1'b1, 1'b0, 1'b0);
      sr3_r = 16'h0000;

      // R6: permission codes
      par_m[slot(0, 0, 4)] = 16'h0100;
      for (int p = 0; p < 8; p++) begin
         pdr_m[slot(0, 0, 4)] = ctl(127, 1'b0, p);
         issue($sformatf("R6 read code %0d", p), 16'h8040, 2'b00, 1'b0, 1'b0, 1'b0);
         sr0_r = 16'h0001;
      end
      foreach (pdr_m[k]) if (k == slot(0, 0, 4)) pdr_m[k] = ctl(127, 1'b0, 2);
      issue("R6 write code 2", 16'h8040, 2'b00, 1'b0, 1'b1, 1'b0);
      sr0_r = 16'h0001;
      pdr_m[slot(0, 0, 4)] = ctl(127, 1'b0, 6);
      issue("R6 write code 6", 16'h8040, 2'b00, 1'b0, 1'b1, 1'b0);

      // R7: length, both directions
      pdr_m[slot(0, 0, 5)] = ctl(5, 1'b0, 6);
      issue("R7 up at limit", 16'hA000 | (16'd5 << 6), 2'b00, 1'b0, 1'b0, 1'b0);
      issue("R7 up above", 16'hA000 | (16'd6 << 6), 2'b00, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h0001;
      pdr_m[slot(0, 0, 5)] = ctl(5, 1'b1, 6);
      issue("R7 down below", 16'hA000 | (16'd4 << 6), 2'b00, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h0001;
      issue("R7 down at limit", 16'hA000 | (16'd5 << 6), 2'b00, 1'b0, 1'b0, 1'b0);
      issue("R7 down top", 16'hBFC0, 2'b00, 1'b0, 1'b0, 1'b0);

      // R8: residency
      par_m[slot(0, 0, 6)] = 16'h0BFF;
      issue("R8 last byte", 16'hC03F, 2'b00, 1'b0, 1'b0, 1'b0);
      par_m[slot(0, 0, 6)] = 16'h0C00;
      issue("R8 first absent", 16'hC000, 2'b00, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h0001;
      par_m[slot(0, 0, 6)] = 16'h2000;
      issue("R8 narrow wraps low", 16'hC000, 2'b00, 1'b0, 1'b0, 1'b0);
      sr3_r = 16'h0010;
      issue("R8 wide absent", 16'hC000, 2'b00, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h0001;
      sr3_r = 16'h0000;

      // R9: priority
      par_m[slot(0, 0, 6)] = 16'h0C00;
      pdr_m[slot(0, 0, 6)] = ctl(0, 1'b0, 0);
      issue("R9 absent over permission", 16'hC0C0, 2'b00, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h0001;
      pdr_m[slot(0, 0, 5)] = ctl(0, 1'b0, 0);
      issue("R9 permission over length", 16'hA0C0, 2'b00, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h0001;
      pdr_m[slot(0, 0, 5)] = ctl(0, 1'b0, 6);
      issue("R9 length alone", 16'hA0C0, 2'b00, 1'b0, 1'b0, 1'b0);

      // R10: capture word and freeze
      sr0_r = 16'h4001;
      issue("R10 frozen", 16'hA0C0, 2'b00, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h1F81;
      sr3_r = 16'h0001;
      pdr_m[slot(3, 1, 3)] = ctl(127, 1'b0, 1);
      issue("R10 capture fields", 16'h6000, 2'b11, 1'b1, 1'b0, 1'b0);
      sr3_r = 16'h0000;

      // R11: descriptor marks
      sr0_r = 16'h0001;
      pdr_m[slot(1, 0, 2)] = ctl(127, 1'b0, 2);
      issue("R11 write abort mark", 16'h4010, 2'b01, 1'b0, 1'b1, 1'b0);
      sr0_r = 16'h0001;
      pdr_m[slot(1, 0, 2)] = ctl(127, 1'b0, 6);
      issue("R11 word write mark", 16'h4010, 2'b01, 1'b0, 1'b1, 1'b0);
      issue("R11 byte write none", 16'h4010, 2'b01, 1'b0, 1'b1, 1'b1);
      issue("R11 odd word none", 16'h4011, 2'b01, 1'b0, 1'b1, 1'b0);
      pdr_m[slot(1, 0, 2)] = ctl(127, 1'b0, 0);
      issue("R11 read abort none", 16'h4010, 2'b01, 1'b0, 1'b0, 1'b0);
      sr0_r = 16'h0001;

      // R12: back-to-back strobes
      pdr_m[slot(0, 0, 5)] = ctl(0, 1'b0, 6);
      issue("R12 abort first", 16'hA0C0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
      issue("R12 clean second", 16'hA000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
      issue("R12 abort third", 16'hA0C0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
      idle(2);
      check("R12 idle strobe", !abort && !rsp_valid && !sr0_we,
            $sformatf("a=%b v=%b", abort, rsp_valid), "a=0 v=0");
      idle(2);
      check("R12 all answered", exp_q.size() == 0,
            $sformatf("%0d pending", exp_q.size()), "0 pending");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule